// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This block takes up to fourteen interrupt request lines, keeps a sticky pending flag for each one, and decides which request, if any, the processor should take next. Software sets a per-source enable, a per-source priority and a single master enable through a small register port. When a request qualifies, the controller raises a take strobe. Alongside it, the controller presents the winning source's entry address and its priority level.

The processor confirms that it has taken the interrupt with a one-cycle acknowledge. On that cycle the controller clears the winner's pending flag and records the winner's level as in service. A one-cycle return pulse retires the highest level in service. A request can interrupt only when its level is strictly above every level in service. Because of this, interrupt handlers nest at most three deep, and a handler cannot be preempted by a request at its own level or below.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every source enable, the master enable, every priority field, every pending flag and every in-service level read or behave as zero, and `irqTake` is low.
- R2: A high `irqReq[n]` at a rising clock edge sets pending flag n. The pending flags read back at register address 3 with source n at bit n. Writes to address 3 are ignored. A request in the same cycle as the acknowledge that would clear that flag leaves the flag set.
- R3: `irqTake` is high exactly when some source is pending, its enable bit (address 0, bit n) is set, the master enable (address 1, bit 0) is set, and its level is strictly above the highest level in service.
- R4: While the master enable is clear, no source raises `irqTake`. Pending flags are kept and take effect once the master enable is set again.
- R5: The priority of source n is held at address 2, bits 2n+1 down to 2n. The values 0, 1 and 2 select levels 0 (lowest) to 2 (highest), and the value 3 acts as level 2.
- R6: Among the qualifying sources, the one at the highest level wins. Within a level, the lowest-numbered source wins.
- R7: While `irqTake` is high, `irqVector` equals 16'h0003 + 8*n for winning source n, and `irqLevel` gives its level.
- R8: `irqAck` while `irqTake` is high clears the winner's pending flag and marks its level as in service. `irqAck` while `irqTake` is low changes nothing.
- R9: While a level is in service, requests at that level or below are held off, and requests at a higher level still interrupt.
- R10: `retiPulse` clears only the highest in-service level. When `retiPulse` and an accepted `irqAck` arrive in the same cycle, the clear applies to the levels in service before that cycle, and the new level is then added.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irqReq | input | NUM_SRC | Request lines, one per source, sampled every edge |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 enables, 1 master enable, 2 priorities, 3 pending |
| regWdata | input | 2*NUM_SRC | Register write data |
| regRdata | output | 2*NUM_SRC | Register read data for `regAddr`, combinational |
| irqAck | input | 1 | Processor has taken the presented interrupt |
| retiPulse | input | 1 | Processor has returned from the current handler |
| irqTake | output | 1 | A qualifying interrupt is presented |
| irqVector | output | VEC_W | Entry address of the presented source |
| irqLevel | output | 2 | Level of the presented source |

## Verification
The checker assumes that `irqAck` and `retiPulse` are single-cycle pulses. It also assumes that the processor sends `irqAck` only while it samples `irqTake` high, and sends `retiPulse` only when a handler is active. An acknowledge with `irqTake` low is still defined as having no effect. The stimulus changes every input on the falling edge and holds each pulse for exactly one rising edge. It sends return pulses only to match earlier acknowledges. The one deliberate exception is an acknowledge with nothing presented, which tests that the acknowledge has no effect.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  localparam int LVL_COUNT = 3;

  // control-to-datapath strobes
  typedef struct packed {
    logic       ackFire;
    logic       retiFire;
    logic [1:0] ackLvl;
    logic       wrEnable;
    logic       wrGlobal;
    logic       wrPrio;
  } irqStrobe_t;

  // field value 3 behaves as the top level
  function automatic logic [1:0] effLevel(input logic [1:0] field);
    return (field == 2'd3) ? 2'd2 : field;
  endfunction

endpackage

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC    = 14,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic [NUM_SRC-1:0]   pend,
  input  logic [NUM_SRC-1:0]   srcEn,
  input  logic [2*NUM_SRC-1:0] prioPacked,
  input  logic                 globalEn,
  input  logic [LVL_COUNT-1:0] inSvc,
  input  logic                 irqAck,
  input  logic                 retiPulse,
  input  logic                 regWe,
  input  logic [1:0]           regAddr,
  output irqStrobe_t           strobe,
  output logic [NUM_SRC-1:0]   winOneHot,
  output logic                 irqTake,
  output logic [VEC_W-1:0]     irqVector,
  output logic [1:0]           irqLevel
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [1:0]           srcLvl [NUM_SRC];
  logic [NUM_SRC-1:0]   elig;
  logic [2:0]           curCode;
  logic [LVL_COUNT-1:0] lvlHit;
  logic [1:0]           bestLvl;
  logic [IDX_W-1:0]     winIdx;
  logic                 found;

  // current code: 0 = idle, L+1 = level L is the top one in service
  always_comb begin
    if (inSvc[2])      curCode = 3'd3;
    else if (inSvc[1]) curCode = 3'd2;
    else if (inSvc[0]) curCode = 3'd1;
    else               curCode = 3'd0;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign srcLvl[g] = effLevel(prioPacked[2*g +: 2]);
    assign elig[g]   = globalEn & srcEn[g] & pend[g] &
                       (({1'b0, srcLvl[g]} + 3'd1) > curCode);
  end

  always_comb begin
    lvlHit = '0;
    for (int n = 0; n < NUM_SRC; n++) begin
      for (int l = 0; l < LVL_COUNT; l++) begin
        if (elig[n] && (srcLvl[n] == 2'(l))) lvlHit[l] = 1'b1;
      end
    end
    bestLvl = 2'd0;
    for (int l = 0; l < LVL_COUNT; l++) begin
      if (lvlHit[l]) bestLvl = 2'(l);
    end
    winIdx = '0;
    for (int n = NUM_SRC - 1; n >= 0; n--) begin
      if (elig[n] && (srcLvl[n] == bestLvl)) winIdx = IDX_W'(n);
    end
    found = |elig;
  end

  assign irqTake   = found;
  assign irqLevel  = bestLvl;
  assign winOneHot = found ? (NUM_SRC'(1) << winIdx) : '0;
  assign irqVector = VEC_W'(VEC_BASE) + VEC_W'(VEC_STRIDE) * VEC_W'(winIdx);

  always_comb begin
    strobe          = '0;
    strobe.ackFire  = irqAck & found;
    strobe.retiFire = retiPulse;
    strobe.ackLvl   = bestLvl;
    strobe.wrEnable = regWe & (regAddr == 2'd0);
    strobe.wrGlobal = regWe & (regAddr == 2'd1);
    strobe.wrPrio   = regWe & (regAddr == 2'd2);
  end

endmodule

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   irqReq,
  input  logic [1:0]           regAddr,
  input  logic [2*NUM_SRC-1:0] regWdata,
  input  irqStrobe_t           strobe,
  input  logic [NUM_SRC-1:0]   winOneHot,
  output logic [NUM_SRC-1:0]   pend,
  output logic [NUM_SRC-1:0]   srcEn,
  output logic [2*NUM_SRC-1:0] prioPacked,
  output logic                 globalEn,
  output logic [LVL_COUNT-1:0] inSvc,
  output logic [2*NUM_SRC-1:0] regRdata
);

  localparam int REG_W = 2 * NUM_SRC;

  logic [LVL_COUNT-1:0] topMask;
  logic [LVL_COUNT-1:0] inSvcNext;
  logic [NUM_SRC-1:0]   pendNext;

  always_comb begin
    if (inSvc[2])      topMask = 3'b100;
    else if (inSvc[1]) topMask = 3'b010;
    else if (inSvc[0]) topMask = 3'b001;
    else               topMask = 3'b000;

    inSvcNext = inSvc;
    if (strobe.retiFire) inSvcNext = inSvcNext & ~topMask;
    if (strobe.ackFire)  inSvcNext = inSvcNext | (3'b001 << strobe.ackLvl);

    pendNext = pend;
    if (strobe.ackFire) pendNext = pendNext & ~winOneHot;
    pendNext = pendNext | irqReq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= '0;
      srcEn      <= '0;
      prioPacked <= '0;
      globalEn   <= 1'b0;
      inSvc      <= '0;
    end else begin
      pend  <= pendNext;
      inSvc <= inSvcNext;
      if (strobe.wrEnable) srcEn      <= regWdata[NUM_SRC-1:0];
      if (strobe.wrGlobal) globalEn   <= regWdata[0];
      if (strobe.wrPrio)   prioPacked <= regWdata;
    end
  end

  always_comb begin
    unique case (regAddr)
      2'd0:    regRdata = REG_W'(srcEn);
      2'd1:    regRdata = REG_W'(globalEn);
      2'd2:    regRdata = prioPacked;
      default: regRdata = REG_W'(pend);
    endcase
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC    = 14,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   irqReq,
  input  logic                 regWe,
  input  logic [1:0]           regAddr,
  input  logic [2*NUM_SRC-1:0] regWdata,
  output logic [2*NUM_SRC-1:0] regRdata,
  input  logic                 irqAck,
  input  logic                 retiPulse,
  output logic                 irqTake,
  output logic [VEC_W-1:0]     irqVector,
  output logic [1:0]           irqLevel
);

  irqStrobe_t           strobe;
  logic [NUM_SRC-1:0]   winOneHot;
  logic [NUM_SRC-1:0]   pend;
  logic [NUM_SRC-1:0]   srcEn;
  logic [2*NUM_SRC-1:0] prioPacked;
  logic                 globalEn;
  logic [LVL_COUNT-1:0] inSvc;

  prio_irq_arb #(
    .NUM_SRC   (NUM_SRC),
    .VEC_W     (VEC_W),
    .VEC_BASE  (VEC_BASE),
    .VEC_STRIDE(VEC_STRIDE)
  ) u_arb (
    .pend      (pend),
    .srcEn     (srcEn),
    .prioPacked(prioPacked),
    .globalEn  (globalEn),
    .inSvc     (inSvc),
    .irqAck    (irqAck),
    .retiPulse (retiPulse),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .strobe    (strobe),
    .winOneHot (winOneHot),
    .irqTake   (irqTake),
    .irqVector (irqVector),
    .irqLevel  (irqLevel)
  );

  prio_irq_regs #(
    .NUM_SRC(NUM_SRC)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .irqReq    (irqReq),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .strobe    (strobe),
    .winOneHot (winOneHot),
    .pend      (pend),
    .srcEn     (srcEn),
    .prioPacked(prioPacked),
    .globalEn  (globalEn),
    .inSvc     (inSvc),
    .regRdata  (regRdata)
  );

endmodule

// File: rtl/prio_irq_checker.sv
module prio_irq_checker #(
  parameter int NUM_SRC = 14,
  parameter int VEC_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irqReq,
  input logic               irqAck,
  input logic               retiPulse,
  input logic               irqTake,
  input logic [VEC_W-1:0]   irqVector,
  input logic [1:0]         irqLevel,
  input logic               globalEn,
  input logic [NUM_SRC-1:0] pend,
  input logic [2:0]         inSvc,
  input logic [NUM_SRC-1:0] winOneHot
);

  AST_TAKE_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    irqTake |-> globalEn); // R4

  AST_TAKE_ABOVE_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    irqTake |-> ((irqLevel == 2'd2) ? !inSvc[2] :
                 (irqLevel == 2'd1) ? (inSvc[2:1] == 2'b00) : (inSvc == 3'b000))); // R9

  AST_REQ_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (irqReq != '0) |=> ((pend & $past(irqReq)) == $past(irqReq))); // R2

  AST_ACK_CLEARS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (irqAck && irqTake && ((irqReq & winOneHot) == '0)) |=> ((pend & $past(winOneHot)) == '0)); // R8

  AST_ACK_MARKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irqAck && irqTake) |=> (((inSvc >> $past(irqLevel)) & 3'b001) != 3'b000)); // R8

  AST_RETI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (retiPulse && !(irqAck && irqTake) && (inSvc != 3'b000))
      |=> ($countones(inSvc) == $countones($past(inSvc)) - 1)); // R10

  AST_VECTOR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    irqTake |-> (irqVector[2:0] == 3'd3)); // R7

  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(winOneHot)); // R6

endmodule

bind prio_irq_ctrl prio_irq_checker #(
  .NUM_SRC(NUM_SRC),
  .VEC_W  (VEC_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irqReq   (irqReq),
  .irqAck   (irqAck),
  .retiPulse(retiPulse),
  .irqTake  (irqTake),
  .irqVector(irqVector),
  .irqLevel (irqLevel),
  .globalEn (globalEn),
  .pend     (pend),
  .inSvc    (inSvc),
  .winOneHot(winOneHot)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;

  localparam int NS = 14;
  localparam int RW = 2 * NS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irqReq = '0;
  logic          regWe = 1'b0;
  logic [1:0]    regAddr = 2'd0;
  logic [RW-1:0] regWdata = '0;
  logic [RW-1:0] regRdata;
  logic          irqAck = 1'b0;
  logic          retiPulse = 1'b0;
  logic          irqTake;
  logic [15:0]   irqVector;
  logic [1:0]    irqLevel;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irqReq(irqReq), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqAck(irqAck), .retiPulse(retiPulse),
    .irqTake(irqTake), .irqVector(irqVector), .irqLevel(irqLevel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rst_n = 1'b0; irqReq = '0; regWe = 1'b0; irqAck = 1'b0; retiPulse = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [RW-1:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    tick();
    regWe = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [RW-1:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic raise(input logic [NS-1:0] m);
    irqReq = m; tick(); irqReq = '0;
  endtask

  task automatic ack();
    irqAck = 1'b1; tick(); irqAck = 1'b0;
  endtask

  task automatic reti();
    retiPulse = 1'b1; tick(); retiPulse = 1'b0;
  endtask

  task automatic setupAll(input logic [RW-1:0] prio);
    doReset();
    writeReg(2'd0, RW'(14'h3FFF));
    writeReg(2'd1, RW'(1));
    writeReg(2'd2, prio);
  endtask

  task automatic t_reset();
    logic [RW-1:0] d;
    doReset();
    for (int a = 0; a < 4; a++) begin
      readReg(2'(a), d);
      chk("R1 register zero", 32'(d), 0);
    end
    chk("R1 take low", 32'(irqTake), 0);
  endtask

  task automatic t_pendingMaster();
    logic [RW-1:0] d;
    doReset();
    raise(14'h0010);
    readReg(2'd3, d);
    chk("R2 pending set", 32'(d), 32'h10);
    chk("R3 not enabled", 32'(irqTake), 0);
    writeReg(2'd3, '0);
    readReg(2'd3, d);
    chk("R2 pending write ignored", 32'(d), 32'h10);
    writeReg(2'd0, RW'(14'h0010));
    chk("R4 master off blocks", 32'(irqTake), 0);
    writeReg(2'd1, RW'(1));
    chk("R3 take", 32'(irqTake), 1);
    chk("R7 vector src4", 32'(irqVector), 35);
    chk("R7 level", 32'(irqLevel), 0);
    writeReg(2'd1, '0);
    chk("R4 master cleared", 32'(irqTake), 0);
    readReg(2'd3, d);
    chk("R4 pending kept", 32'(d), 32'h10);
    writeReg(2'd1, RW'(1));
    chk("R4 master restored", 32'(irqTake), 1);
    writeReg(2'd0, '0);
    chk("R3 source enable off", 32'(irqTake), 0);
  endtask

  task automatic t_vectorEdges();
    logic [RW-1:0] d;
    setupAll('0);
    raise(14'h2000);
    chk("R7 vector src13", 32'(irqVector), 107);
    ack();
    readReg(2'd3, d);
    chk("R8 pending cleared", 32'(d), 0);
    chk("R8 take after ack", 32'(irqTake), 0);
    reti();
    raise(14'h0001);
    chk("R7 vector src0", 32'(irqVector), 3);
  endtask

  task automatic t_tie();
    setupAll('0);
    raise(14'h0208);
    chk("R6 tie lowest", 32'(irqVector), 27);
  endtask

  task automatic t_levels();
    setupAll(RW'(1) << 18);
    raise(14'h0208);
    chk("R6 higher level wins", 32'(irqVector), 75);
    chk("R6 level", 32'(irqLevel), 1);
    writeReg(2'd2, (RW'(1) << 18) | (RW'(3) << 6));
    chk("R5 field 3 top", 32'(irqVector), 27);
    chk("R5 field 3 level", 32'(irqLevel), 2);
    writeReg(2'd2, (RW'(2) << 18) | (RW'(3) << 6));
    chk("R5 3 equals 2 tie", 32'(irqVector), 27);
  endtask

  task automatic t_nesting();
    logic [RW-1:0] d;
    setupAll(RW'(1) << 14);
    raise(14'h0004);
    ack();
    readReg(2'd3, d);
    chk("R8 src2 cleared", 32'(d), 0);
    raise(14'h0020);
    chk("R9 equal level held", 32'(irqTake), 0);
    raise(14'h0080);
    chk("R9 higher preempts", 32'(irqTake), 1);
    chk("R9 vector src7", 32'(irqVector), 59);
    ack();
    chk("R9 nested blocks", 32'(irqTake), 0);
    reti();
    chk("R10 level0 still busy", 32'(irqTake), 0);
    reti();
    chk("R10 all retired", 32'(irqTake), 1);
    chk("R10 vector src5", 32'(irqVector), 43);
  endtask

  task automatic t_ackIgnored();
    setupAll('0);
    ack();
    raise(14'h0002);
    chk("R8 idle ack no effect", 32'(irqTake), 1);
  endtask

  task automatic t_retiWithAck();
    setupAll(RW'(2) << 12 | RW'(1) << 8);
    raise(14'h0002);
    ack();
    raise(14'h0040);
    chk("R10 level2 presented", 32'(irqLevel), 2);
    irqAck = 1'b1; retiPulse = 1'b1;
    tick();
    irqAck = 1'b0; retiPulse = 1'b0;
    raise(14'h0010);
    chk("R10 new level kept", 32'(irqTake), 0);
    reti();
    chk("R10 old level gone", 32'(irqTake), 1);
    chk("R10 vector src4", 32'(irqVector), 35);
  endtask

  task automatic t_reqDuringAck();
    logic [RW-1:0] d;
    setupAll('0);
    raise(14'h0004);
    irqReq = 14'h0004; irqAck = 1'b1;
    tick();
    irqReq = '0; irqAck = 1'b0;
    readReg(2'd3, d);
    chk("R2 request beats clear", 32'(d), 32'h4);
  endtask

  initial begin
    #(4 * 200000);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_pendingMaster();
    t_vectorEdges();
    t_tie();
    t_levels();
    t_nesting();
    t_ackIgnored();
    t_retiWithAck();
    t_reqDuringAck();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule